// File: doc/BRIEF.md
# Vertical Sync Conditioner

This block turns a raw vertical sync into a clean, well-timed vertical sync for a pixel-clock pipeline. The raw pulse comes either from a dedicated input pin or from an upstream sync separator. Its active level is either measured from the signal itself or forced by control bits. The conditioned pulse can be snapped to horizontal sync leading edges, so that per-frame line counts stay exact. Its width can be replaced by a programmed number of lines, and it leaves the block at a programmable polarity.

The control inputs are static fields that a register file elsewhere drives. Software normally powers up with the forced input polarity high, the output polarity high and a duration of 10 lines. `hsync_i` is taken as active high and synchronous to `clk_i`.

Top module: `vsync_cond`

## Requirements
- R1: The separator input `vsync_sep_i` is the source when both `src_en_i` and `src_sel_i` are 1. In every other case `vsync_pin_i` is the source, and the unused candidate has no effect on `vsync_o`.
- R2: With `pol_ovr_i`=1, `pol_in_i`=1 makes a high input level active and `pol_in_i`=0 makes a low input level active.
- R3: With `pol_ovr_i`=0, the block measures the high and low run lengths of the source and treats the shorter level as active. Until both levels have been measured, the high level is taken as active.
- R4: `pol_out_i`=1 drives an active `vsync_o` high and `pol_out_i`=0 drives it low. After reset `vsync_o` is 0.
- R5: Unfiltered, non-reshaped path: `vsync_o` reflects a new source level on the second rising clock edge after the input changes. It is unchanged on the first edge.
- R6: With `filt_en_i`=1, the conditioned level changes only at horizontal sync leading edges. If `hsync_i` is first seen high at clock edge e while the source is active, `vsync_o` is active from edge e+2. Source changes between hsync edges do not reach the output, and deassertion is aligned the same way.
- R7: With `dur_en_i`=1, a new active pulse lasts exactly N line periods, N = `dur_i`. It ends two edges after the edge that first sees the N-th following hsync leading edge. The trailing edge of the source has no effect: a short source pulse is lengthened and a long one is cut.
- R8: With `dur_en_i`=1, `dur_i`=0 gives a pulse of one line period.
- R9: While a reshaped pulse is active, a fresh source pulse neither restarts nor extends it. With `dur_en_i`=0, the filtered width passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_pin_i | input | 1 | Vertical sync candidate from input pin |
| vsync_sep_i | input | 1 | Vertical sync candidate from sync separator |
| src_en_i | input | 1 | Enables source selection by `src_sel_i` |
| src_sel_i | input | 1 | 0: pin, 1: separator (when enabled) |
| pol_ovr_i | input | 1 | 0: detect input polarity, 1: use `pol_in_i` |
| pol_in_i | input | 1 | Forced input polarity, 1 = active high |
| pol_out_i | input | 1 | Output polarity, 1 = active high |
| filt_en_i | input | 1 | Align the pulse to hsync leading edges |
| dur_en_i | input | 1 | Replace the pulse width with `dur_i` lines |
| dur_i | input | DUR_W | Output width in lines (0 means 1) |
| vsync_o | output | 1 | Conditioned vertical sync |

## Verification
Every result has a fixed latency. On the direct path the output moves on the second clock edge after an input change. On the filtered path it moves two edges after the edge that captures an hsync leading edge, and a reshaped pulse ends two edges after the edge that captures its N-th counted hsync. The bench drives all inputs at falling edges and checks the output at falling edges. It checks at the first edge, where the output must still hold its old value, and at the second edge, where the new value is due. Widths are measured by counting falling-edge samples of the active output while lines with an 8-clock period run, so a reshaped pulse of N lines must give exactly 8N samples.

// File: rtl/vsync_cond_pkg.sv
package vsync_cond_pkg;
  typedef enum logic {POL_LOW = 1'b0, POL_HIGH = 1'b1} pol_e;

  typedef struct packed {
    logic src_en;
    logic src_sel;
    logic pol_ovr;
    logic pol_in;
    logic filt_en;
    logic dur_en;
  } vs_ctrl_t;
endpackage

// File: rtl/vsync_src_pol.sv
module vsync_src_pol
  import vsync_cond_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pin_i,
  input  logic     sep_i,
  input  vs_ctrl_t ctrl_i,
  output logic     active_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             raw_q, raw_d;
  logic             lvl_edge;
  logic [CNT_W-1:0] run_q, hi_len_q, lo_len_q, hi_nxt, lo_nxt;
  logic             hi_v_q, lo_v_q, hi_vn, lo_vn;
  pol_e             det_q;
  logic             act_high;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      raw_d <= 1'b0;
    end else begin
      raw_q <= (ctrl_i.src_en && ctrl_i.src_sel) ? sep_i : pin_i;
      raw_d <= raw_q;
    end
  end

  assign lvl_edge = raw_q ^ raw_d;

  // run that just ended had level raw_d
  always_comb begin
    hi_nxt = hi_len_q;
    lo_nxt = lo_len_q;
    hi_vn  = hi_v_q;
    lo_vn  = lo_v_q;
    if (lvl_edge) begin
      if (raw_d) begin
        hi_nxt = run_q;
        hi_vn  = 1'b1;
      end else begin
        lo_nxt = run_q;
        lo_vn  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      hi_len_q <= '0;
      lo_len_q <= '0;
      hi_v_q   <= 1'b0;
      lo_v_q   <= 1'b0;
      det_q    <= POL_HIGH;
    end else begin
      if (lvl_edge)             run_q <= CNT_W'(1);
      else if (run_q != CNT_MAX) run_q <= run_q + CNT_W'(1);
      hi_len_q <= hi_nxt;
      lo_len_q <= lo_nxt;
      hi_v_q   <= hi_vn;
      lo_v_q   <= lo_vn;
      if (lvl_edge && hi_vn && lo_vn) begin
        if (hi_nxt < lo_nxt)      det_q <= POL_HIGH;
        else if (lo_nxt < hi_nxt) det_q <= POL_LOW;
      end
    end
  end

  assign act_high = ctrl_i.pol_ovr ? ctrl_i.pol_in : (det_q == POL_HIGH);
  assign active_o = act_high ? raw_q : ~raw_q;

  // R3: detected polarity only moves on a level change of the source
  a_r3_det_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_edge |=> $stable(det_q));
endmodule

// File: rtl/vsync_line_filter.sv
module vsync_line_filter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic active_i,
  input  logic filt_en_i,
  output logic hs_rise_o,
  output logic filt_o
);
  logic hs_q, hs_d, filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q   <= 1'b0;
      hs_d   <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      hs_q <= hsync_i;
      hs_d <= hs_q;
      if (hs_rise_o) filt_q <= active_i;
    end
  end

  assign hs_rise_o = hs_q & ~hs_d;
  assign filt_o    = filt_en_i ? filt_q : active_i;

  // R6: line-aligned level changes only at hsync leading edges
  a_r6_filt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_rise_o |=> $stable(filt_q));
endmodule

// File: rtl/vsync_width_shaper.sv
module vsync_width_shaper #(
  parameter int DUR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_rise_i,
  input  logic             f_i,
  input  logic             dur_en_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             act_o
);
  logic             f_prev, f_rise, act_q;
  logic [DUR_W-1:0] cnt_q, n_lines;

  assign f_rise  = f_i & ~f_prev;
  assign n_lines = (dur_i == '0) ? DUR_W'(1) : dur_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_prev <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      f_prev <= f_i;
      if (!dur_en_i) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else if (!act_q && f_rise) begin
        act_q <= 1'b1;
        cnt_q <= n_lines;
      end else if (act_q && hs_rise_i) begin
        if (cnt_q == DUR_W'(1)) begin
          act_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q - DUR_W'(1);
        end
      end
    end
  end

  // start cycle is covered by f_rise so width is whole lines
  assign act_o = dur_en_i ? (act_q | f_rise) : f_i;

  // R7: active pulse always has lines left to count
  a_r7_cnt_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (cnt_q != '0));
  // R7: pulse cannot end between hsync edges
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && dur_en_i && !hs_rise_i) |=> act_q);
  // R9: a new source pulse does not reload the count
  a_r9_no_retrig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && dur_en_i && !hs_rise_i) |=> $stable(cnt_q));
endmodule

// File: rtl/vsync_cond.sv
module vsync_cond
  import vsync_cond_pkg::*;
#(
  parameter int DUR_W = 8,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_pin_i,
  input  logic             vsync_sep_i,
  input  logic             src_en_i,
  input  logic             src_sel_i,
  input  logic             pol_ovr_i,
  input  logic             pol_in_i,
  input  logic             pol_out_i,
  input  logic             filt_en_i,
  input  logic             dur_en_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             vsync_o
);
  vs_ctrl_t ctrl;
  logic     active, hs_rise, filt, shaped, vs_q;

  assign ctrl = '{src_en: src_en_i, src_sel: src_sel_i, pol_ovr: pol_ovr_i,
                  pol_in: pol_in_i, filt_en: filt_en_i, dur_en: dur_en_i};

  vsync_src_pol #(.CNT_W(CNT_W)) u_src_pol (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (vsync_pin_i),
    .sep_i    (vsync_sep_i),
    .ctrl_i   (ctrl),
    .active_o (active)
  );

  vsync_line_filter u_filter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hsync_i   (hsync_i),
    .active_i  (active),
    .filt_en_i (ctrl.filt_en),
    .hs_rise_o (hs_rise),
    .filt_o    (filt)
  );

  vsync_width_shaper #(.DUR_W(DUR_W)) u_shaper (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hs_rise_i (hs_rise),
    .f_i       (filt),
    .dur_en_i  (ctrl.dur_en),
    .dur_i     (dur_i),
    .act_o     (shaped)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vs_q <= 1'b0;
    else         vs_q <= pol_out_i ? shaped : ~shaped;
  end

  assign vsync_o = vs_q;

  // R4: with output polarity fixed, output follows the shaped level
  a_r4_out_pol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(pol_out_i) && $stable(shaped) && $past(rst_ni)) |=> $stable(vs_q));
endmodule

// File: tb/vsync_cond_bench.sv
module vsync_cond_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b0, pin = 1'b0, sep = 1'b0;
  logic       src_en = 1'b0, src_sel = 1'b0, pol_ovr = 1'b1, pol_in = 1'b1;
  logic       pol_out = 1'b1, filt_en = 1'b0, dur_en = 1'b0;
  logic [7:0] dur = 8'd10;
  logic       vs;
  int         n_chk = 0, n_fail = 0;
  int         width = 0;
  logic       mon_en = 1'b0;

  always #2 clk = ~clk;

  vsync_cond u_vsync_cond (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .vsync_pin_i(pin),
    .vsync_sep_i(sep), .src_en_i(src_en), .src_sel_i(src_sel),
    .pol_ovr_i(pol_ovr), .pol_in_i(pol_in), .pol_out_i(pol_out),
    .filt_en_i(filt_en), .dur_en_i(dur_en), .dur_i(dur), .vsync_o(vs)
  );

  always @(negedge clk) if (mon_en && vs) width <= width + 1;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic line();
    hsync = 1'b1; step(1);
    hsync = 1'b0; step(7);
  endtask

  task automatic t_reset();
    chk("R4 reset", vs, 0);
  endtask

  task automatic t_latency();
    pin = 1'b1; step(1);
    chk("R5 first edge", vs, 0);
    step(1);
    chk("R5 second edge", vs, 1);
    pin = 1'b0; step(2);
    chk("R5 release", vs, 0);
  endtask

  task automatic t_source();
    src_en = 1'b1; src_sel = 1'b1;
    sep = 1'b1; pin = 1'b0; step(2);
    chk("R1 separator", vs, 1);
    sep = 1'b0; pin = 1'b1; step(3);
    chk("R1 pin ignored", vs, 0);
    src_en = 1'b0; step(2);
    chk("R1 enable low picks pin", vs, 1);
    pin = 1'b0; src_sel = 1'b0; step(2);
  endtask

  task automatic t_forced_pol();
    pol_in = 1'b0; pin = 1'b1; step(2);
    chk("R2 active low idle", vs, 0);
    pin = 1'b0; step(2);
    chk("R2 active low asserted", vs, 1);
    pol_in = 1'b1; step(2);
    chk("R2 active high idle", vs, 0);
  endtask

  task automatic t_out_pol();
    pol_out = 1'b0; step(2);
    chk("R4 inverted idle", vs, 1);
    pin = 1'b1; step(2);
    chk("R4 inverted active", vs, 0);
    pin = 1'b0; pol_out = 1'b1; step(2);
  endtask

  task automatic t_auto_pol();
    pol_ovr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      pin = 1'b1; step(30);
      pin = 1'b0; step(5);
    end
    pin = 1'b1; step(10);
    chk("R3 low-active idle", vs, 0);
    pin = 1'b0; step(3);
    chk("R3 low-active pulse", vs, 1);
    for (int i = 0; i < 3; i++) begin
      pin = 1'b0; step(30);
      pin = 1'b1; step(5);
    end
    pin = 1'b0; step(10);
    chk("R3 high-active idle", vs, 0);
    pin = 1'b1; step(3);
    chk("R3 high-active pulse", vs, 1);
    pin = 1'b0; pol_ovr = 1'b1; step(4);
  endtask

  task automatic t_filter();
    filt_en = 1'b1; pin = 1'b1; step(4);
    chk("R6 waits for hsync", vs, 0);
    hsync = 1'b1; step(1);
    hsync = 1'b0; step(1);
    chk("R6 one edge after hsync", vs, 0);
    step(1);
    chk("R6 two edges after hsync", vs, 1);
    pin = 1'b0; step(4);
    chk("R6 trailing held", vs, 1);
    hsync = 1'b1; step(1);
    hsync = 1'b0; step(2);
    chk("R6 trailing aligned", vs, 0);
  endtask

  task automatic t_passthru_width();
    width = 0; mon_en = 1'b1;
    pin = 1'b1; line(); line();
    pin = 1'b0; line(); line();
    mon_en = 1'b0;
    chk("R9 width unchanged", width, 16);
  endtask

  task automatic t_duration();
    dur_en = 1'b1; dur = 8'd3;
    width = 0; mon_en = 1'b1;
    pin = 1'b1; step(2);
    repeat (6) line();
    mon_en = 1'b0;
    chk("R7 long input cut", width, 24);
    pin = 1'b0; line(); line();
    width = 0; mon_en = 1'b1;
    pin = 1'b1; line();
    pin = 1'b0; repeat (5) line();
    mon_en = 1'b0;
    chk("R7 short input lengthened", width, 24);
    width = 0; mon_en = 1'b1;
    pin = 1'b1; line();
    pin = 1'b0; line();
    pin = 1'b1; line();
    pin = 1'b0; repeat (4) line();
    mon_en = 1'b0;
    chk("R9 retrigger ignored", width, 24);
    dur = 8'd0;
    width = 0; mon_en = 1'b1;
    pin = 1'b1; line();
    pin = 1'b0; repeat (5) line();
    mon_en = 1'b0;
    chk("R8 zero is one line", width, 8);
    dur_en = 1'b0; filt_en = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_latency();
    t_source();
    t_forced_pol();
    t_out_pol();
    t_auto_pol();
    t_filter();
    t_passthru_width();
    t_duration();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule